// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block decides which of eight interrupt lines an interrupt controller should act on next. A 3-bit rotation register names the line that currently has the lowest priority, and the line just after it, counting modulo 8, has the highest. Using that circular ranking, the block finds the highest-ranked line that is already being serviced. It also finds the highest-ranked request that is unmasked and ranks strictly above every line in service. Each result comes with a valid flag.

Both results are pure combinational functions of the request, in-service and mask vectors and the rotation register, so they follow their inputs within the same cycle. The rotation register changes only on a clock edge. It moves in three cases: a controller initialisation clears it, a rotating end-of-interrupt loads it with the line that was just retired, and a set-priority command issued with rotation enabled loads it with a given line. Command decoding and interrupt vector formation stay outside the block.

Top module: `irq_prio_resolver`

## Requirements
- R1: With `prio_low` = L, the ranking from highest to lowest is (L+1) mod 8, (L+2) mod 8, …, L. `svc_line` and `pend_line` are 3-bit line numbers in that ranking.
- R2: `svc_valid` is 1 exactly when some `isr` bit is set. `svc_line` is then the highest-ranked line whose `isr` bit is set. With no bit set, `svc_line` is 0.
- R3: A line is a pending candidate only when its `req` bit is 1 and its `mask` bit is 0. `pend_line` always names such a line.
- R4: A candidate is eligible only if it ranks strictly above the highest-ranked in-service line, or if no line is in service. `pend_valid` reports whether any eligible line exists, and `pend_line` names the highest-ranked one.
- R5: When no line is eligible, `pend_valid` is 0 and `pend_line` is 0.
- R6: While `rst_n` is low, and on the edge after `init_clr` is high, `prio_low` becomes 0, so line 0 has the highest priority.
- R7: On an edge where `rot_en` and `eoi_fire` are both 1, `prio_low` is loaded with `eoi_line`.
- R8: On an edge where `rot_en` and `set_fire` are both 1 and `eoi_fire` is 0, `prio_low` is loaded with `set_line`. If both commands arrive together, the end-of-interrupt takes precedence.
- R9: While `rot_en` is 0 and `init_clr` is 0, `eoi_fire` and `set_fire` leave `prio_low` unchanged.
- R10: `svc_*` and `pend_*` settle in the same cycle as their inputs, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 8 | Request bit per line |
| isr | input | 8 | In-service bit per line |
| mask | input | 8 | Mask bit per line; 1 blocks the line |
| init_clr | input | 1 | Controller initialisation; clears the rotation register |
| rot_en | input | 1 | Rotation enabled for the commands in this cycle |
| eoi_fire | input | 1 | End-of-interrupt retired `eoi_line` |
| eoi_line | input | 3 | Line retired by the end-of-interrupt |
| set_fire | input | 1 | Set-priority command |
| set_line | input | 3 | New lowest-priority line for set-priority |
| prio_low | output | 3 | Current lowest-priority line |
| svc_valid | output | 1 | Some line is in service |
| svc_line | output | 3 | Highest-ranked in-service line |
| pend_valid | output | 1 | An eligible pending line exists |
| pend_line | output | 3 | Highest-ranked eligible pending line |

## Verification
The four resolver outputs are due zero cycles after a change on `req`, `isr`, `mask` or `prio_low`. The bench therefore changes these vectors between clock edges and samples one nanosecond later, before the next edge arrives. `prio_low` is due one edge after a command. Commands are driven on a falling edge and the result is read on the following falling edge, so exactly one rising edge falls between the two. The expected ranks are computed as (line − L − 1) mod 8 over every in-service pattern for each of the eight L values.

// File: rtl/irq_prio_pkg.sv
// Package: shared types for the rotating priority resolver.
// Assumes line counts are powers of two so ranks wrap by truncation.
package irq_prio_pkg;
    // Source selected for the next rotation register value
    typedef enum logic [1:0] {
        PRIO_HOLD = 2'd0,
        PRIO_INIT = 2'd1,
        PRIO_EOI  = 2'd2,
        PRIO_SET  = 2'd3
    } prio_op_e;
endpackage

// File: rtl/irq_rot_scan.sv
// Module: circular first-set finder.
// Scans vec starting one past 'low' and wrapping, and returns the first set
// position. 'ahead' marks every position visited before that hit, or all
// positions when nothing is set. Assumes N is a power of two.
module irq_rot_scan #(
    parameter int unsigned N = 8,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] low,
    output logic         found,
    output logic [W-1:0] idx,
    output logic [N-1:0] ahead
);
    logic [W-1:0] pos_w;

    // Walk the ring from highest to lowest rank and stop at the first hit
    always_comb begin
        found = 1'b0;
        idx   = '0;
        ahead = '0;
        pos_w = '0;
        for (int k = 0; k < N; k++) begin
            pos_w = low + W'(1) + W'(k);
            if (!found) begin
                if (vec[pos_w]) begin
                    found = 1'b1;
                    idx   = pos_w;
                end else begin
                    ahead[pos_w] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irq_prio_reg.sv
// Module: rotation register holding the current lowest-priority line.
// Initialisation wins over a rotating EOI, which wins over set-priority.
// Without rotation enabled, commands other than initialisation are ignored.
module irq_prio_reg
    import irq_prio_pkg::*;
#(
    parameter int unsigned N = 8,
    localparam int unsigned W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_clr,
    input  logic         rot_en,
    input  logic         eoi_fire,
    input  logic [W-1:0] eoi_line,
    input  logic         set_fire,
    input  logic [W-1:0] set_line,
    output logic [W-1:0] prio_low
);
    prio_op_e op;

    // Pick the update source by fixed precedence
    always_comb begin
        if (init_clr)                 op = PRIO_INIT;
        else if (rot_en && eoi_fire)  op = PRIO_EOI;
        else if (rot_en && set_fire)  op = PRIO_SET;
        else                          op = PRIO_HOLD;
    end

    // Register the lowest-priority line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_low <= '0;
        end else begin
            case (op)
                PRIO_INIT: prio_low <= '0;
                PRIO_EOI:  prio_low <= eoi_line;
                PRIO_SET:  prio_low <= set_line;
                default:   prio_low <= prio_low;
            endcase
        end
    end

    assert_init_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |=> prio_low == '0);
    assert_eoi_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_en && eoi_fire && !init_clr) |=> prio_low == $past(eoi_line));
    assert_set_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_en && set_fire && !eoi_fire && !init_clr) |=> prio_low == $past(set_line));
    assert_hold_norot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rot_en && !init_clr) |=> $stable(prio_low));
endmodule

// File: rtl/irq_prio_resolver.sv
// Module: top of the rotating interrupt priority resolver.
// Two ring scans share the rotation register. The first finds the top
// in-service line. Its 'ahead' mask then cuts the pending search off at
// that line, so a request of equal or lower rank never preempts.
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int unsigned N_LINES = 8,
    localparam int unsigned W = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req,
    input  logic [N_LINES-1:0] isr,
    input  logic [N_LINES-1:0] mask,
    input  logic               init_clr,
    input  logic               rot_en,
    input  logic               eoi_fire,
    input  logic [W-1:0]       eoi_line,
    input  logic               set_fire,
    input  logic [W-1:0]       set_line,
    output logic [W-1:0]       prio_low,
    output logic               svc_valid,
    output logic [W-1:0]       svc_line,
    output logic               pend_valid,
    output logic [W-1:0]       pend_line
);
    logic [N_LINES-1:0] above_svc;
    logic [N_LINES-1:0] svc_ahead_unused;
    logic [N_LINES-1:0] cand;
    logic [W-1:0]       rank_pend;
    logic [W-1:0]       rank_svc;

    irq_prio_reg #(.N(N_LINES)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_clr (init_clr),
        .rot_en   (rot_en),
        .eoi_fire (eoi_fire),
        .eoi_line (eoi_line),
        .set_fire (set_fire),
        .set_line (set_line),
        .prio_low (prio_low)
    );

    irq_rot_scan #(.N(N_LINES)) u_svc_scan (
        .vec   (isr),
        .low   (prio_low),
        .found (svc_valid),
        .idx   (svc_line),
        .ahead (above_svc)
    );

    // Unmasked requests that outrank every line in service
    always_comb cand = req & ~mask & above_svc;

    irq_rot_scan #(.N(N_LINES)) u_pend_scan (
        .vec   (cand),
        .low   (prio_low),
        .found (pend_valid),
        .idx   (pend_line),
        .ahead (svc_ahead_unused)
    );

    // Ranks of both winners, 0 = highest, for the ordering check
    always_comb begin
        rank_pend = pend_line - prio_low - W'(1);
        rank_svc  = svc_line - prio_low - W'(1);
    end

    assert_svc_bit_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> isr[svc_line]);
    assert_pend_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (req[pend_line] && !mask[pend_line]));
    assert_pend_outranks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && svc_valid) |-> (rank_pend < rank_svc));
    assert_none_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |-> pend_line == '0);
endmodule

// File: tb/sim_irq_prio_resolver.sv
`timescale 1ns/1ps
module sim_irq_prio_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0, isr = '0, mask = '0;
    logic       init_clr = 1'b0, rot_en = 1'b0, eoi_fire = 1'b0, set_fire = 1'b0;
    logic [2:0] eoi_line = '0, set_line = '0;
    logic [2:0] prio_low, svc_line, pend_line;
    logic       svc_valid, pend_valid;
    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    irq_prio_resolver u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .isr(isr), .mask(mask),
        .init_clr(init_clr), .rot_en(rot_en), .eoi_fire(eoi_fire),
        .eoi_line(eoi_line), .set_fire(set_fire), .set_line(set_line),
        .prio_low(prio_low), .svc_valid(svc_valid), .svc_line(svc_line),
        .pend_valid(pend_valid), .pend_line(pend_line)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rank_of(input int line, input int low);
        return (line - low - 1) & 7;
    endfunction

    // Drive one command on a falling edge; the result is read one edge later
    task automatic command(input logic i, input logic r, input logic e, input int el,
                           input logic s, input int sl);
        @(negedge clk);
        init_clr = i; rot_en = r; eoi_fire = e; eoi_line = 3'(el);
        set_fire = s; set_line = 3'(sl);
        @(negedge clk);
        init_clr = 0; rot_en = 0; eoi_fire = 0; set_fire = 0;
    endtask

    // Apply vectors, wait less than one edge, compare with the rank model
    task automatic check_vec(input int low, input logic [7:0] r, input logic [7:0] s,
                             input logic [7:0] m);
        int best_s, best_p, svc_exp, pend_exp;
        best_s = 8; best_p = 8; svc_exp = 0; pend_exp = 0;
        req = r; isr = s; mask = m;
        #1;
        for (int p = 0; p < 8; p++)
            if (s[p] && rank_of(p, low) < best_s) begin best_s = rank_of(p, low); svc_exp = p; end
        for (int p = 0; p < 8; p++)
            if (r[p] && !m[p] && rank_of(p, low) < best_s && rank_of(p, low) < best_p) begin
                best_p = rank_of(p, low); pend_exp = p;
            end
        chk("R2 svc_valid", 32'(svc_valid), 32'(best_s < 8));
        chk("R1 svc_line", 32'(svc_line), 32'(svc_exp));
        chk("R4 pend_valid", 32'(pend_valid), 32'(best_p < 8));
        chk(best_p < 8 ? "R3 pend_line" : "R5 pend_line", 32'(pend_line), 32'(pend_exp));
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Reset state with quiet inputs
        repeat (3) @(negedge clk);
        chk("R6 reset prio_low", 32'(prio_low), 0);
        chk("R2 reset svc_valid", 32'(svc_valid), 0);
        chk("R5 reset pend_valid", 32'(pend_valid), 0);
        rst_n = 1'b1;

        // Sweep every in-service pattern, a spread of requests, LCG masks
        for (int low = 0; low < 8; low++) begin
            command(0, 1, 0, 0, 1, low);
            chk("R8 set_prio", 32'(prio_low), 32'(low));
            for (int s = 0; s < 256; s++) begin
                for (int r = 0; r < 256; r += 3) begin
                    lcg = lcg * 32'd1664525 + 32'd1013904223;
                    check_vec(low, 8'(r), 8'(s), (lcg[27:24] == 0) ? 8'h00 : lcg[23:16]);
                end
            end
        end

        // Rotating end-of-interrupt
        command(0, 1, 1, 5, 0, 0);
        chk("R7 eoi rotate", 32'(prio_low), 5);
        // Both commands together: the end-of-interrupt wins
        command(0, 1, 1, 6, 1, 2);
        chk("R8 eoi over set", 32'(prio_low), 6);
        // Commands without rotation are ignored
        command(0, 0, 1, 1, 1, 3);
        chk("R9 no rotation", 32'(prio_low), 6);
        // Initialisation returns line 0 to top priority
        command(1, 1, 1, 4, 0, 0);
        chk("R6 init clears", 32'(prio_low), 0);

        // Same-cycle response and directed cutoff with L = 0
        @(negedge clk);
        isr = 8'h08; req = 8'h2A; mask = 8'h00;
        #1;
        chk("R10 comb svc_line", 32'(svc_line), 3);
        chk("R10 comb pend_line", 32'(pend_line), 1);
        req = 8'h20;
        #1;
        chk("R4 lower rank blocked", 32'(pend_valid), 0);
        req = 8'h08;
        #1;
        chk("R4 equal rank blocked", 32'(pend_valid), 0);
        isr = 8'h00; req = 8'h81; mask = 8'h01;
        #1;
        chk("R3 masked skipped", 32'(pend_line), 7);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule